// File: doc/BRIEF.md
# Power-Management Event Status and Enable Block

This block holds the two 16-bit words through which an operating system sees fixed power-management events: a status word of sticky event flags and an enable word that selects which flags may interrupt. Software reaches them over a simple I/O-port bus. The status word sits at the base port and the enable word two ports above it. A status flag is cleared by writing a one to its position, and only for the flags that allow this. The enable word keeps only the bits the block supports.

Hardware sources set the flags. The power-button request sets its flag, but only while an arm input from the command logic says that the power-management mode is on. A separate vector of set requests serves the other event sources (timer, global lock, sleep button, real-time clock, wake, bus master). The block drives a registered, active-low, level-sensitive system-control interrupt. The interrupt is low while any flag in the interrupting group is set together with its enable bit.

Top module: `pm1_evt_block`

## Requirements
- R1: After reset the status and enable words read 0x0000, `sci_n` is high, and `io_ok` and `io_err` are low.
- R2: A request to the status port (0x400) or the enable port (0x402) with `io_bytes` = 2 raises `io_ok` for one cycle on the next clock. Any other size at those ports raises `io_err` instead and changes neither word. Requests to any other port raise neither flag and change nothing.
- R3: A good read of the status port returns, on the cycle `io_ok` is high, the status word as it stood when the request was sampled.
- R4: A status write clears exactly those of bits 15 (wake), 10 (RTC), 9 (sleep button), 8 (power button) and 4 (bus master) that are written as one. Bit 0 (timer), bit 5 (global) and every other bit are left unchanged.
- R5: An enable write stores only bits 8 (power-button enable) and 5 (global enable) of the data, forces every other bit to zero, and a read of the enable port returns the stored value.
- R6: `btn_evt` with `btn_arm` high sets status bit 8 on the next clock. With `btn_arm` low it has no effect.
- R7: Each bit of `src_set` sets the matching status bit among bits 0, 4, 5, 9, 10 and 15. Bit 8 of `src_set` and bits at unused positions have no effect, and unused status bits always read zero.
- R8: `sci_n` is low exactly when, one clock earlier, some bit among 0, 5, 8, 9 and 10 was set in both the status and the enable word. So it changes one clock after the register update that caused the change.
- R9: When a set request and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R10: Once set, the timer bit (bit 0) stays set until reset, whatever is written to the status port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_req | input | 1 | Bus request valid for one cycle |
| io_wr | input | 1 | 1 = write, 0 = read |
| io_port | input | ADDR_W | I/O port address |
| io_bytes | input | SIZE_W | Access size in bytes |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 16 | Read data, valid with io_ok |
| io_ok | output | 1 | Request accepted (one cycle after request) |
| io_err | output | 1 | Request at a block port with an illegal size |
| src_set | input | 16 | Set requests from other event sources |
| btn_evt | input | 1 | Power-button event pulse |
| btn_arm | input | 1 | Power-management mode enabled; gates btn_evt |
| sci_n | output | 1 | Active-low level system-control interrupt |

## Verification
The hardest cases to reach from the ports are a set request and a write-one-to-clear landing on the same status bit in the same cycle, and the release of the interrupt when the last enabled flag is cleared. The first only happens when the two events line up exactly. The second happens only when the enable word holds a bit whose flag can still be set. Directed sequences build both cases on purpose: the button is fired in the same cycle as a clearing write, and the global enable is dropped while the global flag stays set. Long random runs with sparse set requests and port addresses weighted toward the two words then cover the other interleavings against a bench model.

// File: rtl/pm1_evt_pkg.sv
package pm1_evt_pkg;

  localparam int unsigned WORD_W = 16;
  typedef logic [WORD_W-1:0] pm1_word_t;

  // status flag positions
  localparam pm1_word_t F_TMR = 16'h0001;
  localparam pm1_word_t F_BM  = 16'h0010;
  localparam pm1_word_t F_GBL = 16'h0020;
  localparam pm1_word_t F_PWR = 16'h0100;
  localparam pm1_word_t F_SLP = 16'h0200;
  localparam pm1_word_t F_RTC = 16'h0400;
  localparam pm1_word_t F_WAK = 16'h8000;

  // derived groups
  localparam pm1_word_t STS_IMPL  = F_TMR | F_BM | F_GBL | F_PWR | F_SLP | F_RTC | F_WAK;
  localparam pm1_word_t STS_W1C   = F_WAK | F_RTC | F_SLP | F_PWR | F_BM;
  localparam pm1_word_t SRC_MASK  = STS_IMPL & ~F_PWR;
  localparam pm1_word_t EN_KEEP   = F_PWR | F_GBL;
  localparam pm1_word_t IRQ_GROUP = F_TMR | F_GBL | F_PWR | F_SLP | F_RTC;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STS  = 2'd1,
    SEL_EN   = 2'd2
  } pm1_sel_e;

endpackage

// File: rtl/pm1_port_decode.sv
module pm1_port_decode
  import pm1_evt_pkg::*;
#(
  parameter int unsigned          ADDR_W    = 16,
  parameter int unsigned          SIZE_W    = 3,
  parameter int unsigned          ACC_BYTES = 2,
  parameter logic [ADDR_W-1:0]    STS_PORT  = 'h400,
  parameter logic [ADDR_W-1:0]    EN_PORT   = 'h402
) (
  input  logic              io_req,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_port,
  input  logic [SIZE_W-1:0] io_bytes,
  output pm1_sel_e          sel,
  output logic              acc_ok,
  output logic              acc_bad,
  output logic              sts_wr,
  output logic              en_wr
);

  localparam logic [SIZE_W-1:0] GOOD_SIZE = SIZE_W'(ACC_BYTES);

  logic hit;
  logic size_good;

  always_comb begin
    if (io_port == STS_PORT)     sel = SEL_STS;
    else if (io_port == EN_PORT) sel = SEL_EN;
    else                         sel = SEL_NONE;
  end

  assign hit       = io_req && (sel != SEL_NONE);
  assign size_good = (io_bytes == GOOD_SIZE);
  assign acc_ok    = hit && size_good;
  assign acc_bad   = hit && !size_good;
  assign sts_wr    = acc_ok && io_wr && (sel == SEL_STS);
  assign en_wr     = acc_ok && io_wr && (sel == SEL_EN);

endmodule

// File: rtl/pm1_status_reg.sv
module pm1_status_reg
  import pm1_evt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_stb,
  input  pm1_word_t wdata,
  input  pm1_word_t set_vec,
  output pm1_word_t sts_q
);

  pm1_word_t clr_vec;
  pm1_word_t sts_d;

  // set wins over clear in the same cycle
  assign clr_vec = wr_stb ? (wdata & STS_W1C) : '0;
  assign sts_d   = ((sts_q & ~clr_vec) | set_vec) & STS_IMPL;

  always_ff @(posedge clk) begin
    if (rst) sts_q <= '0;
    else     sts_q <= sts_d;
  end

endmodule

// File: rtl/pm1_enable_reg.sv
module pm1_enable_reg
  import pm1_evt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_stb,
  input  pm1_word_t wdata,
  output pm1_word_t en_q
);

  always_ff @(posedge clk) begin
    if (rst)         en_q <= '0;
    else if (wr_stb) en_q <= wdata & EN_KEEP;
  end

endmodule

// File: rtl/pm1_sci_gen.sv
module pm1_sci_gen
  import pm1_evt_pkg::*;
#(
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  logic      clk,
  input  logic      rst,
  input  pm1_word_t sts,
  input  pm1_word_t en,
  output logic      irq
);

  logic need;
  assign need = |(sts & en & IRQ_GROUP);

  generate
    if (ACTIVE_LOW) begin : g_low
      always_ff @(posedge clk) begin
        if (rst) irq <= 1'b1;
        else     irq <= ~need;
      end
    end else begin : g_high
      always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= need;
      end
    end
  endgenerate

endmodule

// File: rtl/pm1_evt_block.sv
module pm1_evt_block
  import pm1_evt_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter int unsigned       SIZE_W    = 3,
  parameter int unsigned       ACC_BYTES = 2,
  parameter logic [ADDR_W-1:0] STS_PORT  = 'h400
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              io_req,
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_port,
  input  logic [SIZE_W-1:0] io_bytes,
  input  logic [15:0]       io_wdata,
  output logic [15:0]       io_rdata,
  output logic              io_ok,
  output logic              io_err,
  input  logic [15:0]       src_set,
  input  logic              btn_evt,
  input  logic              btn_arm,
  output logic              sci_n
);

  localparam logic [ADDR_W-1:0] EN_PORT = STS_PORT + ADDR_W'(2);

  pm1_sel_e  sel;
  logic      acc_ok, acc_bad, sts_wr, en_wr;
  pm1_word_t sts_q, en_q, set_vec;

  pm1_port_decode #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .ACC_BYTES(ACC_BYTES),
    .STS_PORT(STS_PORT), .EN_PORT(EN_PORT)
  ) u_dec (
    .io_req(io_req), .io_wr(io_wr), .io_port(io_port), .io_bytes(io_bytes),
    .sel(sel), .acc_ok(acc_ok), .acc_bad(acc_bad),
    .sts_wr(sts_wr), .en_wr(en_wr)
  );

  // button only while armed; other sources through their own mask
  assign set_vec = (src_set & SRC_MASK) | ((btn_evt && btn_arm) ? F_PWR : '0);

  pm1_status_reg u_sts (
    .clk(clk), .rst(rst), .wr_stb(sts_wr), .wdata(io_wdata),
    .set_vec(set_vec), .sts_q(sts_q)
  );

  pm1_enable_reg u_en (
    .clk(clk), .rst(rst), .wr_stb(en_wr), .wdata(io_wdata), .en_q(en_q)
  );

  pm1_sci_gen #(.ACTIVE_LOW(1'b1)) u_sci (
    .clk(clk), .rst(rst), .sts(sts_q), .en(en_q), .irq(sci_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      io_ok    <= 1'b0;
      io_err   <= 1'b0;
      io_rdata <= '0;
    end else begin
      io_ok  <= acc_ok;
      io_err <= acc_bad;
      if (acc_ok && !io_wr)
        io_rdata <= (sel == SEL_STS) ? sts_q : en_q;
      else
        io_rdata <= '0;
    end
  end

endmodule

// File: rtl/pm1_evt_chk.sv
module pm1_evt_chk
  import pm1_evt_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter int unsigned       SIZE_W    = 3,
  parameter int unsigned       ACC_BYTES = 2,
  parameter logic [ADDR_W-1:0] STS_PORT  = 'h400
) (
  input logic              clk,
  input logic              rst,
  input logic              io_req,
  input logic              io_wr,
  input logic [ADDR_W-1:0] io_port,
  input logic [SIZE_W-1:0] io_bytes,
  input logic [15:0]       io_wdata,
  input logic              io_ok,
  input logic              io_err,
  input logic              btn_evt,
  input logic              btn_arm,
  input logic              sci_n,
  input logic [15:0]       sts,
  input logic [15:0]       en
);

  localparam logic [ADDR_W-1:0] EN_A = STS_PORT + ADDR_W'(2);

  logic at_blk, good_sz, sts_write;
  assign at_blk    = io_req && (io_port == STS_PORT || io_port == EN_A);
  assign good_sz   = (io_bytes == SIZE_W'(ACC_BYTES));
  assign sts_write = at_blk && good_sz && io_wr && (io_port == STS_PORT);

  // R2
  bad_size_chk: assert property (@(posedge clk) disable iff (rst)
    (at_blk && !good_sz) |=> (io_err && !io_ok));

  // R2
  good_size_chk: assert property (@(posedge clk) disable iff (rst)
    (at_blk && good_sz) |=> (io_ok && !io_err));

  // R5
  en_store_chk: assert property (@(posedge clk) disable iff (rst)
    (at_blk && good_sz && io_wr && io_port == EN_A) |=> (en == ($past(io_wdata) & EN_KEEP)));

  // R6
  btn_set_chk: assert property (@(posedge clk) disable iff (rst)
    (btn_evt && btn_arm) |=> sts[8]);

  // R6
  btn_unarmed_chk: assert property (@(posedge clk) disable iff (rst)
    (!btn_arm && !sts_write) |=> !$rose(sts[8]));

  // R8
  sci_low_chk: assert property (@(posedge clk) disable iff (rst)
    (|(sts & en & IRQ_GROUP)) |=> !sci_n);

  // R8
  sci_high_chk: assert property (@(posedge clk) disable iff (rst)
    !(|(sts & en & IRQ_GROUP)) |=> sci_n);

  // R10
  tmr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    sts[0] |=> sts[0]);

endmodule

bind pm1_evt_block pm1_evt_chk #(
  .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .ACC_BYTES(ACC_BYTES), .STS_PORT(STS_PORT)
) u_chk (
  .clk(clk), .rst(rst), .io_req(io_req), .io_wr(io_wr), .io_port(io_port),
  .io_bytes(io_bytes), .io_wdata(io_wdata), .io_ok(io_ok), .io_err(io_err),
  .btn_evt(btn_evt), .btn_arm(btn_arm), .sci_n(sci_n), .sts(sts_q), .en(en_q)
);

// File: tb/sim_pm1_evt_block.sv
`timescale 1ns/1ps
module sim_pm1_evt_block;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_req = 1'b0, io_wr = 1'b0;
  logic [15:0] io_port = '0;
  logic [2:0]  io_bytes = '0;
  logic [15:0] io_wdata = '0, src_set = '0;
  logic        btn_evt = 1'b0, btn_arm = 1'b0;
  logic [15:0] io_rdata;
  logic        io_ok, io_err, sci_n;

  int n_chk = 0, n_fail = 0;
  logic [15:0] m_sts = '0, m_en = '0;
  bit finished = 0;

  always #2 clk = ~clk;

  pm1_evt_block u0 (
    .clk(clk), .rst(rst), .io_req(io_req), .io_wr(io_wr), .io_port(io_port),
    .io_bytes(io_bytes), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_ok(io_ok), .io_err(io_err), .src_set(src_set), .btn_evt(btn_evt),
    .btn_arm(btn_arm), .sci_n(sci_n)
  );

  function automatic logic exp_sci_n(logic [15:0] s, logic [15:0] e);
    return !(|(s & e & 16'h0721));
  endfunction

  function automatic logic [15:0] exp_set(logic [15:0] src, logic b, logic a);
    return (src & 16'h8631) | ((b && a) ? 16'h0100 : 16'h0000);
  endfunction

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bus cycle plus checks against the model
  task automatic cyc(input logic req, input logic wr, input logic [15:0] port,
                     input logic [2:0] bytes, input logic [15:0] wd,
                     input logic [15:0] src, input logic b, input logic a,
                     input string tag);
    logic hit, good;
    logic [15:0] clr;
    @(negedge clk);
    io_req = req; io_wr = wr; io_port = port; io_bytes = bytes;
    io_wdata = wd; src_set = src; btn_evt = b; btn_arm = a;
    @(posedge clk); #1;
    hit  = req && (port == 16'h0400 || port == 16'h0402);
    good = hit && (bytes == 3'd2);
    chk({15'd0, sci_n}, {15'd0, exp_sci_n(m_sts, m_en)}, "R8 sci level");
    chk({15'd0, io_ok}, {15'd0, good}, "R2 ok");
    chk({15'd0, io_err}, {15'd0, hit && !good}, "R2 err");
    if (good && !wr)
      chk(io_rdata, (port == 16'h0400) ? m_sts : m_en, tag);
    clr = (good && wr && port == 16'h0400) ? (wd & 16'h8710) : 16'h0000;
    m_sts = ((m_sts & ~clr) | exp_set(src, b, a)) & 16'h8731;
    if (good && wr && port == 16'h0402) m_en = wd & 16'h0120;
    @(negedge clk);
    io_req = 1'b0; btn_evt = 1'b0; src_set = '0;
  endtask

  task automatic rd_expect(input logic [15:0] port, input logic [15:0] exp, input string tag);
    cyc(1'b1, 1'b0, port, 3'd2, 16'h0, 16'h0, 1'b0, btn_arm, tag);
    chk(io_rdata, exp, tag);
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, 16'h0, 3'd0, 16'h0, 16'h0, 1'b0, btn_arm, "idle");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4177));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    #1;
    chk({15'd0, sci_n}, 16'h1, "R1 sci_n");
    chk({14'd0, io_ok, io_err}, 16'h0, "R1 ok/err");
    rd_expect(16'h0400, 16'h0000, "R1 status");
    rd_expect(16'h0402, 16'h0000, "R1 enable");

    // R7 and R6: all sources, button fired while unarmed
    cyc(1'b0, 1'b0, 16'h0, 3'd0, 16'h0, 16'hFFFF, 1'b1, 1'b0, "R7");
    rd_expect(16'h0400, 16'h8631, "R7 src set / R6 unarmed");

    // R4 write ones everywhere
    cyc(1'b1, 1'b1, 16'h0400, 3'd2, 16'hFFFF, 16'h0, 1'b0, 1'b0, "R4");
    rd_expect(16'h0400, 16'h0021, "R4 w1c subset");
    cyc(1'b1, 1'b1, 16'h0400, 3'd2, 16'hFFFF, 16'h0, 1'b0, 1'b0, "R10");
    rd_expect(16'h0400, 16'h0021, "R10 timer sticky");

    // R5 enable mask
    cyc(1'b1, 1'b1, 16'h0402, 3'd2, 16'hFFFF, 16'h0, 1'b0, 1'b0, "R5");
    rd_expect(16'h0402, 16'h0120, "R5 enable mask");
    chk({15'd0, sci_n}, 16'h0, "R8 global asserts");

    // R8 release by dropping global enable
    cyc(1'b1, 1'b1, 16'h0402, 3'd2, 16'h0100, 16'h0, 1'b0, 1'b0, "R8");
    idle();
    chk({15'd0, sci_n}, 16'h1, "R8 release");

    // R6 armed button
    cyc(1'b0, 1'b0, 16'h0, 3'd0, 16'h0, 16'h0, 1'b1, 1'b1, "R6");
    rd_expect(16'h0400, 16'h0121, "R6 armed button");
    chk({15'd0, sci_n}, 16'h0, "R6 button interrupt");

    // R9 clear and set together
    cyc(1'b1, 1'b1, 16'h0400, 3'd2, 16'h0100, 16'h0, 1'b1, 1'b1, "R9");
    rd_expect(16'h0400, 16'h0121, "R9 set wins");
    cyc(1'b1, 1'b1, 16'h0400, 3'd2, 16'h0100, 16'h0, 1'b0, 1'b1, "R4");
    idle();
    chk({15'd0, sci_n}, 16'h1, "R8 release after clear");

    // R2 bad size and foreign port
    cyc(1'b1, 1'b1, 16'h0402, 3'd1, 16'h0000, 16'h0, 1'b0, 1'b1, "R2");
    cyc(1'b1, 1'b1, 16'h0404, 3'd2, 16'h0000, 16'h0, 1'b0, 1'b1, "R2");
    rd_expect(16'h0402, 16'h0100, "R2 enable untouched");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] p, src;
      logic [2:0]  bsz;
      int r;
      r = $urandom_range(0, 9);
      p = (r < 4) ? 16'h0400 : (r < 8) ? 16'h0402 : (r == 8) ? 16'h0404 : 16'($urandom);
      r = $urandom_range(0, 9);
      bsz = (r < 8) ? 3'd2 : (r == 8) ? 3'd1 : 3'd4;
      src = ($urandom_range(0, 9) == 0) ? (16'h1 << $urandom_range(0, 15)) : 16'h0;
      cyc($urandom_range(0, 9) < 7, 1'($urandom), p, bsz, 16'($urandom), src,
          $urandom_range(0, 9) == 0, 1'($urandom), "R3 read");
    end
    finish_run();
  end

endmodule